// File: doc/BRIEF.md
# Configurable PAL Output Macrocell Bank

This block holds a row of output macrocells for a programmable AND-OR array. Each cell takes one sum-of-products term from the array, an output-enable term and a two-bit mode word. It drives one bidirectional pin and sends one feedback line back into the array. All cell registers share one clock, so every registered path is synchronous.

The mode word sets three things at once: whether the pin shows the live sum term or the registered copy, whether that value is inverted, and whether the feedback line is taken from the pin or from the register. Mode 00 drives the sum term as is. Mode 01 drives it inverted. Mode 10 drives the register. Mode 11 drives the inverted register. In the two combinational modes the feedback follows the pin level. When the driver is off, that level comes from outside, so the cell then works as an input. In the two registered modes the feedback is the true register output, whatever the pin polarity or enable.

The data paths are single-bit levels with no transfer semantics, so every port is a plain control or data pin and there is no valid/ready handshake and no back-pressure.

Top module: `pal_macrocell_bank`

## Requirements
- R1: With mode 00 (`mode_i[c]` = 2'b00) and `oe_i[c]` high, `pin_io[c]` equals `sum_i[c]` in the same cycle.
- R2: With mode 01 and `oe_i[c]` high, `pin_io[c]` equals the inverse of `sum_i[c]` in the same cycle.
- R3: With mode 10 and `oe_i[c]` high, `pin_io[c]` equals the value `sum_i[c]` had at the previous rising clock edge.
- R4: With mode 11 and `oe_i[c]` high, `pin_io[c]` equals the inverse of the value `sum_i[c]` had at the previous rising clock edge.
- R5: In modes 10 and 11 (`mode_i[c][1]` = 1), `fb_o[c]` equals the register value, which is `sum_i[c]` at the previous rising edge, regardless of `mode_i[c][0]`, `oe_i[c]` or the external pin level.
- R6: In modes 00 and 01 (`mode_i[c][1]` = 0), `fb_o[c]` equals the level on `pin_io[c]`. With the driver on, that is the driven value, inverted in mode 01.
- R7: With `oe_i[c]` low, the cell releases `pin_io[c]` to high impedance, so an external driver sets the pin level. In modes 00 and 01 that external level then appears on `fb_o[c]`.
- R8: A rising clock edge with `rst_i` high clears every cell register to 0. On the next cycle, modes 10 and 11 show feedback 0 and a pin of 0 or 1 respectively.
- R9: Every cell register loads its sum term on every edge in every mode. A change of mode neither clears nor freezes the register.
- R10: A change of `mode_i[c]` changes `pin_io[c]` and `fb_o[c]` in the same cycle, without waiting for a clock edge.
- R11: The cells are independent. The inputs of one cell have no effect on the pin or feedback of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by all cell registers |
| rst_i | input | 1 | Synchronous reset, active high, clears the registers |
| sum_i | input | CELLS | Sum-of-products term for each cell |
| oe_i | input | CELLS | Output-enable term for each cell, high drives the pin |
| mode_i | input | CELLS x 2 | Mode word per cell: bit 1 selects registered, bit 0 selects inversion |
| pin_io | inout | CELLS | Bidirectional pin of each cell |
| fb_o | output | CELLS | Feedback line to the array for each cell |

## Verification
The assertions check the following on every cycle:
- pin polarity and source for each mode while the driver is on;
- feedback equal to the pin level in the combinational modes;
- feedback equal to the previous cycle's sum term in the registered modes;
- zero feedback after a reset edge.

Only the bench scenarios can show that an enable-low cell really lets go of its pin, because that needs an outside driver whose level must come back on the pin and the feedback. They also show that the registers keep tracking through mode changes from one cycle to the next, and that the cells stay apart while their inputs differ at random.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  // Bit 1 picks the registered path, bit 0 inverts the pin value.
  typedef enum logic [1:0] {
    MODE_COMB   = 2'b00,
    MODE_COMB_N = 2'b01,
    MODE_REG    = 2'b10,
    MODE_REG_N  = 2'b11
  } pmc_mode_t;

endpackage

// File: rtl/pmc_capture.sv
module pmc_capture (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  // Loads on every edge, independent of mode, so a mode switch keeps the data.
  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= 1'b0;
    else       q_o <= d_i;
  end

endmodule

// File: rtl/pmc_select.sv
module pmc_select
  import pmc_pkg::*;
(
  input  pmc_mode_t mode_i,
  input  logic      sum_i,
  input  logic      reg_i,
  input  logic      pin_i,
  output logic      drive_o,
  output logic      fb_o
);

  always_comb begin
    unique case (mode_i)
      MODE_COMB:   begin drive_o = sum_i;  fb_o = pin_i; end
      MODE_COMB_N: begin drive_o = ~sum_i; fb_o = pin_i; end
      MODE_REG:    begin drive_o = reg_i;  fb_o = reg_i; end
      MODE_REG_N:  begin drive_o = ~reg_i; fb_o = reg_i; end
      default:     begin drive_o = sum_i;  fb_o = pin_i; end
    endcase
  end

endmodule

// File: rtl/pmc_cell.sv
module pmc_cell
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sum_i,
  input  logic [1:0] mode_i,
  input  logic       pin_i,
  output logic       drive_o,
  output logic       fb_o
);

  logic      reg_q;
  pmc_mode_t mode;

  assign mode = pmc_mode_t'(mode_i);

  pmc_capture u_cap (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (sum_i),
    .q_o   (reg_q)
  );

  pmc_select u_sel (
    .mode_i  (mode),
    .sum_i   (sum_i),
    .reg_i   (reg_q),
    .pin_i   (pin_i),
    .drive_o (drive_o),
    .fb_o    (fb_o)
  );

endmodule

// File: rtl/pal_macrocell_bank.sv
module pal_macrocell_bank #(
  parameter int CELLS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [CELLS-1:0]      sum_i,
  input  logic [CELLS-1:0]      oe_i,
  input  logic [CELLS-1:0][1:0] mode_i,
  inout  wire  [CELLS-1:0]      pin_io,
  output logic [CELLS-1:0]      fb_o
);

  logic [CELLS-1:0] drive;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    pmc_cell u_cell (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sum_i   (sum_i[c]),
      .mode_i  (mode_i[c]),
      .pin_i   (pin_io[c]),
      .drive_o (drive[c]),
      .fb_o    (fb_o[c])
    );

    // The enable is a logic term, so the pin doubles as an input when it is low.
    assign pin_io[c] = oe_i[c] ? drive[c] : 1'bz;
  end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int CELLS = 4
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic [CELLS-1:0]      sum_i,
  input logic [CELLS-1:0]      oe_i,
  input logic [CELLS-1:0][1:0] mode_i,
  input logic [CELLS-1:0]      pin_i,
  input logic [CELLS-1:0]      fb_i
);

  for (genvar c = 0; c < CELLS; c++) begin : g_chk
    // R1, R2, R10: combinational pin follows the live sum with the current polarity
    a_r1_comb_pin: assert property (@(posedge clk_i) disable iff (rst_i)
      (oe_i[c] && !mode_i[c][1]) |-> (pin_i[c] == (sum_i[c] ^ mode_i[c][0])));

    // R3, R4: registered pin shows last edge's sum with the current polarity
    a_r3_reg_pin: assert property (@(posedge clk_i) disable iff (rst_i)
      (oe_i[c] && mode_i[c][1] && !$past(rst_i)) |->
        (pin_i[c] == ($past(sum_i[c]) ^ mode_i[c][0])));

    // R5: registered feedback is the true register value
    a_r5_reg_fb: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i[c][1] && !$past(rst_i)) |-> (fb_i[c] == $past(sum_i[c])));

    // R6: combinational feedback follows the pin level
    a_r6_comb_fb: assert property (@(posedge clk_i) disable iff (rst_i)
      (!mode_i[c][1]) |-> (fb_i[c] == pin_i[c]));

    // R8: register is cleared by a reset edge
    a_r8_reset_fb: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(rst_i) && mode_i[c][1]) |-> (fb_i[c] == 1'b0));
  end

endmodule

bind pal_macrocell_bank pmc_checker #(.CELLS(CELLS)) u_pmc_checker (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .sum_i  (sum_i),
  .oe_i   (oe_i),
  .mode_i (mode_i),
  .pin_i  (pin_io),
  .fb_i   (fb_o)
);

// File: tb/tb_pal_macrocell_bank.sv
`timescale 1ns/1ps
module tb_pal_macrocell_bank;

  localparam int CELLS = 4;
  localparam int STEPS = 3000;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [CELLS-1:0]      sum = '0;
  logic [CELLS-1:0]      oe  = '0;
  logic [CELLS-1:0]      ext = '0;
  logic [CELLS-1:0][1:0] mode = '0;
  wire  [CELLS-1:0]      pin;
  logic [CELLS-1:0]      fb;

  logic [CELLS-1:0] qm = '0;   // bench model of the cell registers
  logic [31:0]      lfsr = 32'h1357_9bdf;
  int               n_vec = 0;
  int               n_bad = 0;
  bit               done  = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar c = 0; c < CELLS; c++) begin : g_ext
    assign pin[c] = oe[c] ? 1'bz : ext[c];
  end

  pal_macrocell_bank #(.CELLS(CELLS)) dut (
    .clk_i  (clk),
    .rst_i  (rst),
    .sum_i  (sum),
    .oe_i   (oe),
    .mode_i (mode),
    .pin_io (pin),
    .fb_o   (fb)
  );

  function automatic string pin_tag(input logic en, input logic [1:0] m);
    if (!en)         return "R7";
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check_cells(input string ctx);
    for (int c = 0; c < CELLS; c++) begin
      logic ep, ef;
      ep = oe[c] ? ((mode[c][1] ? qm[c] : sum[c]) ^ mode[c][0]) : ext[c];
      ef = mode[c][1] ? qm[c] : ep;
      n_vec++;
      if (pin[c] !== ep) begin
        n_bad++;
        $display("FAIL %s pin cell %0d (%s, R10 R11): got %b exp %b", pin_tag(oe[c], mode[c]), c, ctx, pin[c], ep);
      end
      n_vec++;
      if (fb[c] !== ef) begin
        n_bad++;
        $display("FAIL %s fb cell %0d (%s, R9): got %b exp %b",
                 mode[c][1] ? "R5" : "R6", c, ctx, fb[c], ef);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    qm = rst ? '0 : sum;
  endtask

  initial begin
    // reset phase: R8
    tick(); tick();
    @(negedge clk);
    rst = 1'b0;
    oe  = '1;
    mode = {2'b11, 2'b10, 2'b11, 2'b10};
    sum = '0;
    #1 check_cells("R8 after reset");
    for (int s = 0; s < STEPS; s++) begin
      tick();
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rst = (s % 97) == 96;
      for (int c = 0; c < CELLS; c++) begin
        sum[c]  = lfsr[c*5];
        oe[c]   = lfsr[c*5+1];
        ext[c]  = lfsr[c*5+2];
        mode[c] = lfsr[c*5+4 -: 2];
      end
      #1 check_cells(rst ? "R8 in reset" : "sweep");
      // R10: mode flip without a clock edge
      if (!rst) begin
        mode[s % CELLS] = mode[s % CELLS] ^ 2'(s % 3 + 1);
        #1 check_cells("R10 mode flip");
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule